// File: doc/BRIEF.md
# Serial LCD command/data transmitter

This block drives a display controller over a four-wire write-only serial link. The four lines are an active-low chip select, a register select line (instruction or data), a serial clock and a serial data line. A host starts a transfer through a valid/ready request port that carries a command-or-data flag and a byte count. It then supplies the payload bytes one at a time through a second valid/ready port.

A command transfer always moves exactly one byte with the register select low. A data transfer moves the requested number of bytes back to back with the register select high, and chip select stays low across every byte boundary. Each bit is put on the data line in the same cycle the clock goes low, and the display captures it on the next rising edge, most significant bit first. A static divider input sets how long each clock phase lasts. When a transfer ends, all four lines go back high, and a single-cycle done pulse marks the first idle cycle.

Top module: `lcd_serial_tx`

## Requirements
- R1: After reset and whenever no transfer is in progress, cs_no, dsel_o, sclk_o and sdat_o are all 1. req_ready_o is 1 in that state and done_o is 0 after reset.
- R2: cs_no goes low exactly once per transfer that moves at least one byte, and it stays low until the last bit of the last byte has finished its high phase.
- R3: While cs_no is low, dsel_o is constant. It is 0 for a command transfer (req_is_data_i = 0) and 1 for a data transfer (req_is_data_i = 1).
- R4: The bits of each byte are presented most significant first. Each bit is the value of sdat_o at a rising edge of sclk_o.
- R5: sdat_o changes only in a cycle where sclk_o is low, and it holds its value for the whole high phase of sclk_o.
- R6: While cs_no is low, every low phase of sclk_o lasts div_i+1 cycles, and every high phase between two bits of the same byte lasts div_i+1 cycles. A div_i of 0 is handled as 1.
- R7: A command transfer sends exactly one byte, whatever value is on req_count_i.
- R8: A data transfer with req_count_i = N ≥ 1 sends exactly N bytes, in the order they were accepted on byte_i.
- R9: A data request with req_count_i = 0 causes no activity on any line and raises done_o in the cycle after it is accepted.
- R10: done_o is high for exactly one cycle per accepted request, and it is high only while all four lines are at their idle level.
- R11: req_ready_o is high only while cs_no is high. byte_ready_o is high only while cs_no is low and sclk_o is high. While no byte is offered, the transfer stalls with the lines held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Clock phase length minus one; static during a transfer |
| req_valid_i | input | 1 | Transfer request offered |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_is_data_i | input | 1 | 1 = data transfer, 0 = command |
| req_count_i | input | CNT_W | Byte count for a data transfer |
| byte_valid_i | input | 1 | Payload byte offered |
| byte_ready_o | output | 1 | Payload byte taken this cycle if valid |
| byte_i | input | BYTE_W | Payload byte |
| cs_no | output | 1 | Chip select, active low |
| dsel_o | output | 1 | Register select: 0 instruction, 1 data |
| sclk_o | output | 1 | Serial clock, idles high |
| sdat_o | output | 1 | Serial data, idles high |
| done_o | output | 1 | One-cycle pulse when a transfer has ended |

## Verification
The hardest case to reach from the ports is a byte boundary inside a data burst where the host holds back the next byte. There, chip select has to stay low, the clock has to stay high and the data line has to hold the previous bit. It must do so for an arbitrary number of cycles before the next low phase starts. The random stimulus inserts gaps of varying length before byte offers, and it does so across several divider values. Directed cases add a zero divider, a zero-count data request and a command request that carries a nonzero count. A line decoder in the bench rebuilds bytes and phase lengths from the pins alone.

// File: rtl/lcd_serial_pkg.sv
package lcd_serial_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } lst_state_e;
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_div;

  // zero divider is clamped to one
  assign eff_div = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = run_i && (cnt_q == eff_div);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/lcd_bit_shifter.sv
module lcd_bit_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  assign msb_o  = sh_q[BYTE_W-1];
  assign last_o = (idx_q == IDX_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
      idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/lcd_xfer_ctrl.sv
module lcd_xfer_ctrl
  import lcd_serial_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_is_data_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              tick_i,
  input  logic              last_bit_i,
  output logic              req_ready_o,
  output logic              byte_ready_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_data_o,
  output logic              shift_o,
  output logic              run_o,
  output logic              is_data_o,
  output lst_state_e        state_o
);
  lst_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             is_data_q, is_data_d;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign byte_ready_o = (state_q == ST_FETCH);
  assign run_o        = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign is_data_o    = is_data_q;
  assign state_o      = state_q;

  always_comb begin
    state_d     = state_q;
    left_d      = left_q;
    is_data_d   = is_data_q;
    load_o      = 1'b0;
    load_data_o = byte_i;
    shift_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          is_data_d   = req_is_data_i;
          left_d      = req_is_data_i ? req_count_i : CNT_W'(1);
          // park data line high for the first fetch
          load_o      = 1'b1;
          load_data_o = '1;
          if (req_is_data_i && (req_count_i == '0)) state_d = ST_DONE;
          else                                      state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (byte_valid_i) begin
          load_o  = 1'b1;
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tick_i) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (tick_i) begin
          if (last_bit_i) begin
            left_d  = left_q - CNT_W'(1);
            state_d = (left_q == CNT_W'(1)) ? ST_DONE : ST_FETCH;
          end else begin
            shift_o = 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      is_data_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      left_q    <= left_d;
      is_data_q <= is_data_d;
    end
  end
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx
  import lcd_serial_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_data_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              cs_no,
  output logic              dsel_o,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              done_o
);
  lst_state_e        state;
  logic              tick, last_bit, load, shift, run, is_data, msb;
  logic [BYTE_W-1:0] load_data;
  logic              idle_lines;

  lcd_xfer_ctrl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_is_data_i(req_is_data_i),
    .req_count_i  (req_count_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .tick_i       (tick),
    .last_bit_i   (last_bit),
    .req_ready_o  (req_ready_o),
    .byte_ready_o (byte_ready_o),
    .load_o       (load),
    .load_data_o  (load_data),
    .shift_o      (shift),
    .run_o        (run),
    .is_data_o    (is_data),
    .state_o      (state)
  );

  lcd_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .run_i (run),
    .tick_o(tick)
  );

  lcd_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (load_data),
    .shift_i(shift),
    .msb_o  (msb),
    .last_o (last_bit)
  );

  assign idle_lines = (state == ST_IDLE) || (state == ST_DONE);
  assign cs_no      = idle_lines;
  assign dsel_o     = idle_lines ? 1'b1 : is_data;
  assign sclk_o     = (state != ST_LOW);
  assign sdat_o     = idle_lines ? 1'b1 : msb;
  assign done_o     = (state == ST_DONE);
endmodule

// File: rtl/lcd_serial_tx_sva.sv
module lcd_serial_tx_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic byte_ready_o,
  input logic cs_no,
  input logic dsel_o,
  input logic sclk_o,
  input logic sdat_o,
  input logic done_o
);
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (dsel_o && sclk_o && sdat_o)); // R1
  AST_DSEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no)) |-> $stable(dsel_o)); // R3
  AST_DATA_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o && $past(sclk_o) && !$past(cs_no)) |-> $stable(sdat_o)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && sclk_o)); // R10
  AST_REQ_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no); // R11
  AST_BYTE_READY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (!cs_no && sclk_o)); // R11
endmodule

bind lcd_serial_tx lcd_serial_tx_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .byte_ready_o(byte_ready_o),
  .cs_no       (cs_no),
  .dsel_o      (dsel_o),
  .sclk_o      (sclk_o),
  .sdat_o      (sdat_o),
  .done_o      (done_o)
);

// File: tb/lcd_serial_tx_tb_top.sv
module lcd_serial_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div = 8'd1;
  logic req_valid = 1'b0, req_is_data = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_d = '0;
  logic req_ready, byte_ready, cs_n, dsel, sclk, sdat, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_serial_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_is_data_i(req_is_data), .req_count_i(req_count),
    .byte_valid_i(byte_valid), .byte_ready_o(byte_ready), .byte_i(byte_d),
    .cs_no(cs_n), .dsel_o(dsel), .sclk_o(sclk), .sdat_o(sdat), .done_o(done)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] tx [0:255];
  logic [7:0] rx [0:255];
  logic       rx_dsel [0:255];
  int rx_n, rx_bit, cs_falls, done_cnt, phase_err, stable_err, idle_err, ready_err;
  int lo_len, hi_len, cur_div;
  logic [7:0] rx_sh;
  logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_sdat = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic clear_mon();
    rx_n = 0; rx_bit = 0; cs_falls = 0; done_cnt = 0;
    phase_err = 0; stable_err = 0; idle_err = 0; ready_err = 0;
    lo_len = 0; hi_len = 0;
  endtask

  // pin-level decoder
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (cs_n && !(dsel && sclk && sdat)) idle_err++;
      if (done && !cs_n) idle_err++;
      if (req_ready && !cs_n) ready_err++;
      if (byte_ready && (cs_n || !sclk)) ready_err++;
      if (prev_cs && !cs_n) cs_falls++;
      if (!cs_n) begin
        if (!sclk) begin
          lo_len++;
          if (prev_sclk && !prev_cs) begin
            if (rx_bit != 0 && hi_len != cur_div + 1) phase_err++;
          end
        end else begin
          if (!prev_sclk) begin
            if (lo_len != cur_div + 1) phase_err++;
            if (sdat != prev_sdat) stable_err++;
            lo_len = 0; hi_len = 1;
            rx_sh = {rx_sh[6:0], sdat};
            rx_bit++;
            if (rx_bit == 8) begin
              rx[rx_n] = rx_sh; rx_dsel[rx_n] = dsel; rx_n++; rx_bit = 0;
            end
          end else begin
            hi_len++;
            if (!prev_cs && sdat != prev_sdat) stable_err++;
          end
        end
      end
      prev_sclk = sclk; prev_cs = cs_n; prev_sdat = sdat;
    end
  end

  task automatic run_xfer(input bit is_data, input int count, input int d, input bit gaps);
    int nb, wt, bad_b, bad_d;
    nb = is_data ? count : 1;
    for (int i = 0; i < nb; i++) tx[i] = 8'($urandom);
    @(posedge clk); #1;
    clear_mon();
    div = 8'(d); cur_div = eff_div(d);
    req_valid = 1'b1; req_is_data = is_data; req_count = 8'(count);
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 1'b0; req_count = 8'($urandom);
    for (int i = 0; i < nb; i++) begin
      if (gaps && ($urandom % 2 == 0)) repeat ($urandom % 5 + 1) @(posedge clk);
      #1;
      byte_valid = 1'b1; byte_d = tx[i];
      forever begin @(negedge clk); if (byte_ready) break; end
      @(posedge clk); #1;
      byte_valid = 1'b0; byte_d = 8'($urandom);
    end
    wt = 0;
    while (!done && wt < 5000) begin @(negedge clk); wt++; end
    repeat (3) @(negedge clk);
    bad_b = 0; bad_d = 0;
    for (int i = 0; i < nb && i < rx_n; i++) begin
      if (rx[i] != tx[i]) bad_b++;
      if (rx_dsel[i] != is_data) bad_d++;
    end
    if (is_data) chk(rx_n == nb, "R8 byte count", rx_n, nb);
    else         chk(rx_n == 1, "R7 command single byte", rx_n, 1);
    chk(bad_b == 0, "R4 byte values msb first", bad_b, 0);
    chk(bad_d == 0, "R3 register select level", bad_d, 0);
    if (nb == 0) chk(cs_falls == 0, "R9 zero count no activity", cs_falls, 0);
    else         chk(cs_falls == 1, "R2 one chip select window", cs_falls, 1);
    chk(done_cnt == 1, "R10 done pulses", done_cnt, 1);
    chk(phase_err == 0, "R6 phase length", phase_err, 0);
    chk(stable_err == 0, "R5 data stable in high phase", stable_err, 0);
    chk(idle_err == 0, "R1 idle lines", idle_err, 0);
    chk(ready_err == 0, "R11 ready only when allowed", ready_err, 0);
  endtask

  task automatic zero_timing();
    int lat;
    @(posedge clk); #1;
    clear_mon();
    req_valid = 1'b1; req_is_data = 1'b1; req_count = '0;
    @(negedge clk);
    @(posedge clk); #1; req_valid = 1'b0;
    @(negedge clk);
    lat = done ? 1 : 0;
    chk(lat == 1, "R9 done one cycle after accept", lat, 1);
    repeat (2) @(negedge clk);
    chk(cs_falls == 0, "R9 lines untouched", cs_falls, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && dsel && sclk && sdat, "R1 reset lines", {cs_n, dsel, sclk, sdat}, 15);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    // directed corners
    run_xfer(1'b0, 0, 1, 1'b0);
    run_xfer(1'b0, 200, 2, 1'b0);   // R7 count ignored
    run_xfer(1'b1, 1, 0, 1'b0);     // R6 zero divider
    run_xfer(1'b1, 0, 3, 1'b0);     // R9
    zero_timing();
    run_xfer(1'b1, 12, 1, 1'b1);    // R2 stalls mid burst
    run_xfer(1'b1, 5, 4, 1'b1);
    // random mix
    for (int k = 0; k < 40; k++)
      run_xfer(1'($urandom % 2), int'($urandom % 7), int'($urandom % 4), 1'($urandom % 2));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule